// File: doc/BRIEF.md
# Pulse-Stretching Digital Phase-Locked Loop

This block builds a line-rate clock and a local 8 kHz frame signal from a master clock that runs a little faster than eight times the wanted line rate. A prescaler divides the master clock by `PRE_DIV` to form the line clock. A frame counter then divides the line clock by a selectable frame length: `DIV_T1` (193) when `frame_sel` is 0, or `DIV_E1` (256) when it is 1. Because the master clock is fast, the loop runs ahead of an 8 kHz reference when nothing is corrected. The only correction is to slow it down. In a frame marked for correction, the master clock is stretched by half a period twice, which adds one full master period to that frame.

The simulation clock `clk` runs at twice the master-clock rate. A master period is therefore two ticks, and a half-cycle stretch is one extra tick in which the divider chain does not advance. A two-flop synchronizer samples the reference, and `edge_rise` chooses which edge is active. An active edge seen while the frame counter is still in the first half of its count means the local frame wrapped before the reference edge. The stretch controller then adds both stretches in the following frame.

The stretch controller is a four-state machine:
- **ST_RUN**: no stretch is pending. It moves to **ST_STALL_A** at a frame wrap when a correction was requested, and otherwise stays in ST_RUN.
- **ST_STALL_A**: one stall tick, straight after the wrap. It always moves to **ST_WAIT_MID**.
- **ST_WAIT_MID**: it waits for the frame midpoint step, then moves to **ST_STALL_B**.
- **ST_STALL_B**: a second stall tick. It always returns to ST_RUN.

Top module: `pdpll_top`

## Requirements
- R1: While `rst_n` is low, `line_clk` and `frame_8k` are 0 and `line_clk_n` is 1. After release, `line_clk` first reads high after the `2*(PRE_DIV/2)`-th rising clock edge and `frame_8k` after the `2*PRE_DIV*(N/2)`-th, where N is the selected frame length.
- R2: `line_clk` has a period of `2*PRE_DIV` ticks. It is high for the upper half of the prescaler count, and `line_clk_n` is always its complement.
- R3: An uncorrected frame lasts `2*PRE_DIV*N` ticks. N is 193 for `frame_sel`=0 and 256 for `frame_sel`=1. `frame_8k` is low for frame counts below N/2 (integer division) and high for the rest, and it changes only when `line_clk` falls.
- R4: An active reference edge detected while `frame_8k` is low makes the next frame exactly 2 ticks longer. Each stretch is a single tick in which no output changes, and two stretch ticks are never adjacent.
- R5: An active edge detected while `frame_8k` is high causes no correction, so the next frame has the uncorrected length.
- R6: In a frame with no active edge, the next frame has no correction. A reference held at a constant level therefore gives jitter-free frames.
- R7: `edge_rise`=1 makes the rising reference edge active and `edge_rise`=0 makes the falling edge active. The other edge has no effect.
- R8: The first stretch falls in the tick right after the frame wrap and the second in the tick right after the midpoint (where `frame_8k` rises). Each half of a corrected frame is therefore one tick longer.
- R9: For a reference period between the uncorrected and the corrected frame lengths, the loop keeps the local frame wrap within 8 ticks of the reference edge.
- R10: The decision is made once per frame. Several early edges in one frame still give exactly two stretch ticks in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation clock at twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | 8 kHz reference (asynchronous) |
| edge_rise | input | 1 | 1: lock to the rising edge, 0: lock to the falling edge |
| frame_sel | input | 1 | 0: frame of DIV_T1 line clocks, 1: frame of DIV_E1 line clocks |
| line_clk | output | 1 | Line-rate clock |
| line_clk_n | output | 1 | Inverse of line_clk |
| frame_8k | output | 1 | Local 8 kHz frame signal; its falling edge is the frame wrap |

## Verification
The bench builds the block with `PRE_DIV`=4 and both frame lengths at their defaults of 193 and 256. This makes a 256-line frame 2048 ticks long, or 2050 when corrected. That is short enough to run many frames, including a 30-frame tracking run with a reference period of 2049 ticks. With those values the bench can measure exact frame lengths, the split of each corrected frame into two halves of 1025 ticks, and how the wrap settles against the reference.

// File: rtl/pdpll_pkg.sv
package pdpll_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_STALL_A  = 2'd1,
        ST_WAIT_MID = 2'd2,
        ST_STALL_B  = 2'd3
    } stretch_state_t;
endpackage

// File: rtl/pdpll_edge_det.sv
module pdpll_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic edge_rise,
    output logic ref_edge
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ref_in};
    end

    // sync_q[1] is the synchronized level, sync_q[2] its previous value
    always_comb begin
        if (edge_rise) ref_edge = sync_q[1] & ~sync_q[2];
        else           ref_edge = ~sync_q[1] & sync_q[2];
    end
endmodule

// File: rtl/pdpll_divider.sv
module pdpll_divider #(
    parameter int PRE_DIV = 8,
    parameter int DIV_T1  = 193,
    parameter int DIV_E1  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic frame_sel,
    output logic line_clk,
    output logic frame_8k,
    output logic wrap,
    output logic mid,
    output logic early
);
    localparam int DIV_MAX = (DIV_E1 > DIV_T1) ? DIV_E1 : DIV_T1;
    localparam int PW      = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam int FW      = $clog2(DIV_MAX + 1);

    logic          half_q;
    logic [PW-1:0] pre_q;
    logic [FW-1:0] frm_q;
    logic [FW-1:0] frame_len;
    logic [FW-1:0] frame_half;
    logic          step;
    logic          pre_last;
    logic          frm_last;

    assign frame_len  = frame_sel ? FW'(DIV_E1) : FW'(DIV_T1);
    assign frame_half = frame_len >> 1;
    assign step       = half_q & ~stall;
    assign pre_last   = (pre_q == PW'(PRE_DIV - 1));
    assign frm_last   = (frm_q >= frame_len - FW'(1));
    assign wrap       = step & pre_last & frm_last;
    assign mid        = step & pre_last & (frm_q == frame_half - FW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            pre_q  <= '0;
            frm_q  <= '0;
        end else begin
            if (!stall) half_q <= ~half_q;
            if (step)   pre_q  <= pre_last ? '0 : pre_q + PW'(1);
            if (step && pre_last) frm_q <= frm_last ? '0 : frm_q + FW'(1);
        end
    end

    assign line_clk = (pre_q >= PW'(PRE_DIV / 2));
    assign frame_8k = (frm_q >= frame_half);
    assign early    = (frm_q < frame_half);
endmodule

// File: rtl/pdpll_stretch_ctl.sv
module pdpll_stretch_ctl
    import pdpll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic mid,
    input  logic stretch_req,
    output logic stall
);
    stretch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            ST_RUN:      if (wrap && stretch_req) state_d = ST_STALL_A;
            ST_STALL_A: begin
                stall   = 1'b1;
                state_d = ST_WAIT_MID;
            end
            ST_WAIT_MID: if (mid) state_d = ST_STALL_B;
            ST_STALL_B: begin
                stall   = 1'b1;
                state_d = ST_RUN;
            end
            default:     state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/pdpll_top.sv
module pdpll_top #(
    parameter int PRE_DIV = 8,
    parameter int DIV_T1  = 193,
    parameter int DIV_E1  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic edge_rise,
    input  logic frame_sel,
    output logic line_clk,
    output logic line_clk_n,
    output logic frame_8k
);
    logic ref_edge;
    logic stall;
    logic wrap;
    logic mid;
    logic early;
    logic early_seen_q;

    pdpll_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .edge_rise(edge_rise),
        .ref_edge (ref_edge)
    );

    pdpll_divider #(
        .PRE_DIV(PRE_DIV),
        .DIV_T1 (DIV_T1),
        .DIV_E1 (DIV_E1)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .frame_sel(frame_sel),
        .line_clk (line_clk),
        .frame_8k (frame_8k),
        .wrap     (wrap),
        .mid      (mid),
        .early    (early)
    );

    // one decision per frame: any edge in the first half marks the local frame as fast
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                early_seen_q <= 1'b0;
        else if (wrap)             early_seen_q <= 1'b0;
        else if (ref_edge && early) early_seen_q <= 1'b1;
    end

    pdpll_stretch_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .mid        (mid),
        .stretch_req(early_seen_q),
        .stall      (stall)
    );

    assign line_clk_n = ~line_clk;
endmodule

// File: rtl/pdpll_checker.sv
module pdpll_checker (
    input logic clk,
    input logic rst_n,
    input logic line_clk,
    input logic line_clk_n,
    input logic frame_8k,
    input logic stall
);
    logic       frame_q;
    logic [1:0] stall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q   <= 1'b0;
            stall_cnt <= 2'd0;
        end else begin
            frame_q <= frame_8k;
            if (frame_q && !frame_8k) stall_cnt <= 2'd0;
            else if (stall && stall_cnt != 2'd3) stall_cnt <= stall_cnt + 2'd1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_low_r1: assert (!line_clk && !frame_8k && line_clk_n);
        end
    end

    p_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_clk_n == ~line_clk);

    p_frame_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_8k) |-> $fell(line_clk));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(line_clk) && $stable(frame_8k)));

    p_stall_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_two_per_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= 2'd2);
endmodule

bind pdpll_top pdpll_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_clk  (line_clk),
    .line_clk_n(line_clk_n),
    .frame_8k  (frame_8k),
    .stall     (stall)
);

// File: tb/pdpll_top_bench.sv
module pdpll_top_bench;
    localparam int PRE  = 4;
    localparam int FR_E = 2 * PRE * 256;
    localparam int FR_T = 2 * PRE * 193;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic edge_rise = 1'b1;
    logic frame_sel = 1'b1;
    logic line_clk, line_clk_n, frame_8k;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int fall_t = 0;
    int rise_t = 0;
    int fall_cnt = 0;
    int n_long = 0;
    logic fr_q = 1'b0;

    pdpll_top #(.PRE_DIV(PRE), .DIV_T1(193), .DIV_E1(256)) u_pdpll_top (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .edge_rise(edge_rise),
        .frame_sel(frame_sel), .line_clk(line_clk), .line_clk_n(line_clk_n),
        .frame_8k(frame_8k)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (fr_q && !frame_8k) begin
            if (fall_cnt > 0 && (cyc - fall_t) == FR_E + 2) n_long = n_long + 1;
            fall_t = cyc;
            fall_cnt = fall_cnt + 1;
        end
        if (!fr_q && frame_8k) rise_t = cyc;
        fr_q = frame_8k;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic next_fall();
        int s;
        s = fall_cnt;
        while (fall_cnt == s) @(negedge clk);
    endtask

    task automatic settle(input bit er, input bit lvl);
        edge_rise = er;
        ref_in = lvl;
        next_fall();
        next_fall();
    endtask

    task automatic t_reset();
        int lc_at, fr_at;
        lc_at = -1;
        fr_at = -1;
        ticks(3);
        check(!line_clk && line_clk_n && !frame_8k, "R1 reset levels", {line_clk, line_clk_n, frame_8k}, 3'b010);
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int k = 1; k <= 1100; k++) begin
            @(posedge clk);
            #1;
            if (lc_at < 0 && line_clk) lc_at = k;
            if (fr_at < 0 && frame_8k) fr_at = k;
        end
        check(lc_at == PRE, "R1 first line_clk edge", lc_at, PRE);
        check(fr_at == 2 * PRE * 128, "R1 first frame_8k edge", fr_at, 2 * PRE * 128);
    endtask

    task automatic t_line_clk();
        int hi, per;
        hi = 0;
        per = 0;
        while (line_clk) @(negedge clk);
        while (!line_clk) @(negedge clk);
        while (line_clk) begin
            hi++;
            per++;
            check(line_clk_n == ~line_clk, "R2 inverse", line_clk_n, ~line_clk);
            @(negedge clk);
        end
        while (!line_clk) begin
            per++;
            @(negedge clk);
        end
        check(hi == PRE, "R2 high width", hi, PRE);
        check(per == 2 * PRE, "R2 period", per, 2 * PRE);
    endtask

    task automatic t_plain_e1();
        int ta;
        settle(1'b1, 1'b1);
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_E, "R6 steady frame", fall_t - ta, FR_E);
        check(rise_t - ta == FR_E / 2, "R3 low half length", rise_t - ta, FR_E / 2);
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_E, "R3 frame length 256", fall_t - ta, FR_E);
    endtask

    task automatic t_early();
        int t0, ta, tb;
        settle(1'b1, 1'b0);
        t0 = fall_t;
        ticks(100);
        ref_in = 1'b1;
        ticks(50);
        ref_in = 1'b0;
        next_fall();
        ta = fall_t;
        check(ta - t0 == FR_E, "R4 edge frame unchanged", ta - t0, FR_E);
        next_fall();
        tb = fall_t;
        check(tb - ta == FR_E + 2, "R4 stretched frame", tb - ta, FR_E + 2);
        check(rise_t - ta == FR_E / 2 + 1, "R8 first half", rise_t - ta, FR_E / 2 + 1);
        check(tb - rise_t == FR_E / 2 + 1, "R8 second half", tb - rise_t, FR_E / 2 + 1);
        next_fall();
        check(fall_t - tb == FR_E, "R6 no edge after", fall_t - tb, FR_E);
    endtask

    task automatic t_late();
        int ta;
        settle(1'b1, 1'b0);
        ticks(FR_E / 2 + 100);
        ref_in = 1'b1;
        ticks(50);
        ref_in = 1'b0;
        next_fall();
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_E, "R5 late edge", fall_t - ta, FR_E);
    endtask

    task automatic t_polarity();
        int ta;
        settle(1'b0, 1'b0);
        ticks(100);
        ref_in = 1'b1;
        ticks(FR_E / 2);
        ref_in = 1'b0;
        next_fall();
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_E, "R7 rising ignored", fall_t - ta, FR_E);
        settle(1'b0, 1'b1);
        ticks(100);
        ref_in = 1'b0;
        ticks(50);
        ref_in = 1'b1;
        next_fall();
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_E + 2, "R7 falling active", fall_t - ta, FR_E + 2);
    endtask

    task automatic t_multi();
        int ta;
        settle(1'b1, 1'b0);
        ticks(100);
        ref_in = 1'b1;
        ticks(50);
        ref_in = 1'b0;
        ticks(100);
        ref_in = 1'b1;
        ticks(50);
        ref_in = 1'b0;
        next_fall();
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_E + 2, "R10 two edges one correction", fall_t - ta, FR_E + 2);
    endtask

    task automatic t_track();
        int d, worst, long0;
        worst = 0;
        settle(1'b1, 1'b0);
        ticks(3);
        long0 = n_long;
        for (int i = 0; i < 30; i++) begin
            ref_in = 1'b1;
            d = cyc - fall_t;
            if (d > FR_E / 2) d = d - FR_E;
            if (d < 0) d = -d;
            if (i >= 20 && d > worst) worst = d;
            ticks(1000);
            ref_in = 1'b0;
            ticks(FR_E + 1 - 1000);
        end
        check(worst <= 8, "R9 wrap offset", worst, 8);
        check(n_long - long0 >= 5, "R9 corrections seen", n_long - long0, 5);
    endtask

    task automatic t_t1();
        int ta;
        frame_sel = 1'b0;
        settle(1'b1, 1'b1);
        ta = fall_t;
        next_fall();
        check(fall_t - ta == FR_T, "R3 frame length 193", fall_t - ta, FR_T);
        check(rise_t - ta == 2 * PRE * 96, "R3 low half 193", rise_t - ta, 2 * PRE * 96);
        frame_sel = 1'b1;
    endtask

    initial begin
        t_reset();
        t_line_clk();
        t_plain_e1();
        t_early();
        t_late();
        t_polarity();
        t_multi();
        t_t1();
        t_track();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk = n_chk + 1;
        n_err = n_err + 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule